// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a synchronous host and an asynchronous static RAM with a 19-bit address and an 8-bit shared data bus. The host hands over one transfer at a time on a valid/ready port: an address, a direction flag and, for a store, a data byte. The controller then produces the active-low chip-select, write-strobe and output-enable lines. It holds each phase for a whole number of clock cycles, and it returns load data with a single-cycle response pulse.

The phase lengths are worked out at elaboration. They come from the clock period, a speed-grade parameter (55, 70, 85, 100 or 120 ns) and a margin of skew cycles. Each length is the ceiling of the grade's minimum time divided by the clock period, plus the margin. A store is strobe-controlled: the output enable stays high for the whole store, and the data pins are driven only while the write strobe is low. After a load there is one dead cycle before anything else starts, so the RAM has released the bus before the controller can drive it. Between transfers the chip select is high, which lets the RAM drop to standby. The pad-level tri-state buffer lives outside the block and is steered by a drive-enable output.

Top module: `sram_strobe_ctl`

## Requirements
- R1: While reset is held and just after it, the chip select, write strobe and output enable are all high, the data drive-enable is low, req_ready is 1 and rsp_valid is 0.
- R2: req_ready is 1 only when no transfer is in progress. A request is taken at a rising edge where req_valid and req_ready are both 1, and req_ready is 0 in the very next cycle.
- R3: A load holds chip select low, output enable low and the write strobe high for RD_CYC = ceil(GRADE_NS/CLK_NS) + MARGIN consecutive cycles (12 at 55 ns, 5 ns clock, margin 1), starting in the cycle right after acceptance.
- R4: Load data present on ram_dq_i in the last load cycle is captured at the closing edge. It appears on rsp_rdata with rsp_valid = 1 for exactly one cycle, the cycle after the last load cycle.
- R5: A store has three parts, all with chip select low. First comes one setup cycle with the write strobe high. Then the write strobe is low for WP_CYC = ceil(max(tWP, tDW, tAW)/CLK_NS) + MARGIN cycles, which is 10 at the default grade (tWP 40, tDW 25, tAW 45 ns). Last come REC_CYC = max(1, WC_CYC - 1 - WP_CYC) recovery cycles with the write strobe high, where WC_CYC = ceil(GRADE_NS/CLK_NS) + MARGIN (1 at the default grade).
- R6: Output enable stays high for the whole store. ram_dq_oe is 1 exactly while the write strobe is low, and it is never 1 while output enable is low.
- R7: After a load there is a turnaround cycle with chip select high, ready low and no drive. It is the cycle that carries rsp_valid, so a store queued behind a load sees two chip-select-high cycles before its setup cycle.
- R8: Chip select is high whenever req_ready is 1, so every pair of transfers is separated by at least one deselected cycle.
- R9: ram_addr equals the accepted address and does not change for as long as chip select stays low.
- R10: During the write-strobe-low cycles, ram_dq_o carries the accepted store byte, and the RAM holds that byte after the strobe rises.
- R11: Request fields presented while req_ready is 0 are ignored. They change neither the address pins, the strobes nor the stored data, and a store never raises rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Store byte |
| rsp_valid | output | 1 | One-cycle pulse marking load data |
| rsp_rdata | output | 8 | Load data |
| ram_addr | output | 19 | RAM address pins |
| ram_ce_n | output | 1 | Active-low chip select |
| ram_we_n | output | 1 | Active-low write strobe |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_dq_o | output | 8 | Data to the pad for stores |
| ram_dq_oe | output | 1 | Pad drive enable |
| ram_dq_i | input | 8 | Data from the pad |

## Verification
Each load's strobes begin in the first cycle after the accepting edge and run for twelve cycles. The response pulse lands one cycle later, in the turnaround cycle. A store's setup cycle likewise follows its accepting edge, then ten strobe-low cycles and one recovery cycle, with ready back at 1 in the next cycle. The bench drives on falling edges and samples every cycle on falling edges. It counts the cycles of each phase instead of waiting a fixed delay, and it compares the counts with figures it derives itself from the grade table. A behavioural RAM in the bench stores on the rising write strobe and drives data only while selected with output enable low, so stored bytes are confirmed by later loads.

// File: rtl/sram_strobe_pkg.sv
package sram_strobe_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_READ   = 3'd1,
    PH_TURN   = 3'd2,
    PH_WSETUP = 3'd3,
    PH_WPULSE = 3'd4,
    PH_WREC   = 3'd5
  } phase_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // minimum write strobe width per grade (ns)
  function automatic int unsigned t_strobe_min(input int unsigned grade);
    case (grade)
      70:      return 50;
      85:      return 55;
      100:     return 60;
      120:     return 65;
      default: return 40;
    endcase
  endfunction

  // data valid before strobe rise (ns)
  function automatic int unsigned t_data_setup(input int unsigned grade);
    case (grade)
      70:      return 30;
      85:      return 35;
      100:     return 40;
      120:     return 45;
      default: return 25;
    endcase
  endfunction

  // address valid to strobe rise (ns)
  function automatic int unsigned t_addr_to_end(input int unsigned grade);
    case (grade)
      70:      return 60;
      85:      return 70;
      100:     return 80;
      120:     return 90;
      default: return 45;
    endcase
  endfunction

  function automatic int unsigned rd_cycles(input int unsigned grade, input int unsigned clk_ns,
                                            input int unsigned margin);
    return ceil_div(grade, clk_ns) + margin;
  endfunction

  function automatic int unsigned wp_cycles(input int unsigned grade, input int unsigned clk_ns,
                                            input int unsigned margin);
    int unsigned worst;
    worst = max2(max2(t_strobe_min(grade), t_data_setup(grade)), t_addr_to_end(grade));
    return ceil_div(worst, clk_ns) + margin;
  endfunction

  function automatic int unsigned rec_cycles(input int unsigned grade, input int unsigned clk_ns,
                                             input int unsigned margin);
    int unsigned wc;
    int unsigned wp;
    wc = ceil_div(grade, clk_ns) + margin;
    wp = wp_cycles(grade, clk_ns, margin);
    if (wc > wp + 2) return wc - 1 - wp;
    return 1;
  endfunction

endpackage

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
  import sram_strobe_pkg::*;
#(
  parameter int unsigned RD_CYC  = 12,
  parameter int unsigned WP_CYC  = 10,
  parameter int unsigned REC_CYC = 1,
  parameter int unsigned CNT_W   = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_write,
  output logic   req_ready,
  output logic   accept,
  output logic   rd_capture,
  output logic   rsp_pulse,
  output logic   ce_n,
  output logic   we_n,
  output logic   oe_n,
  output logic   dq_oe,
  output phase_e phase
);

  localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LOAD  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(REC_CYC - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             phase_last;
  logic             rsp_q;

  assign phase_last = (cnt_q == '0);
  assign req_ready  = (phase_q == PH_IDLE);
  assign accept     = req_ready && req_valid;
  assign rd_capture = (phase_q == PH_READ) && phase_last;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          if (req_write) begin
            phase_d = PH_WSETUP;
            cnt_d   = '0;
          end else begin
            phase_d = PH_READ;
            cnt_d   = RD_LOAD;
          end
        end
      end
      PH_READ: begin
        if (phase_last) phase_d = PH_TURN;
        else            cnt_d   = cnt_q - 1'b1;
      end
      PH_TURN:   phase_d = PH_IDLE;
      PH_WSETUP: begin
        phase_d = PH_WPULSE;
        cnt_d   = WP_LOAD;
      end
      PH_WPULSE: begin
        if (phase_last) begin
          phase_d = PH_WREC;
          cnt_d   = REC_LOAD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_WREC: begin
        if (phase_last) phase_d = PH_IDLE;
        else            cnt_d   = cnt_q - 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      rsp_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      rsp_q   <= rd_capture;
    end
  end

  assign rsp_pulse = rsp_q;
  assign phase     = phase_q;
  assign ce_n      = !((phase_q == PH_READ) || (phase_q == PH_WSETUP) ||
                       (phase_q == PH_WPULSE) || (phase_q == PH_WREC));
  assign we_n      = (phase_q != PH_WPULSE);
  assign oe_n      = (phase_q != PH_READ);
  assign dq_oe     = (phase_q == PH_WPULSE);

endmodule

// File: rtl/sram_strobe_dp.sv
module sram_strobe_dp #(
  parameter int unsigned AW = 19,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          rd_capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] ram_dq_i,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_dq_o,
  output logic [DW-1:0] rsp_rdata
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (rd_capture) rdata_q <= ram_dq_i;
    end
  end

  assign ram_addr  = addr_q;
  assign ram_dq_o  = wdata_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/sram_strobe_ctl.sv
module sram_strobe_ctl
  import sram_strobe_pkg::*;
#(
  parameter int unsigned CLK_NS   = 5,
  parameter int unsigned GRADE_NS = 55,
  parameter int unsigned MARGIN   = 1,
  parameter int unsigned AW       = 19,
  parameter int unsigned DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] ram_addr,
  output logic          ram_ce_n,
  output logic          ram_we_n,
  output logic          ram_oe_n,
  output logic [DW-1:0] ram_dq_o,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_i
);

  localparam int unsigned RD_CYC  = rd_cycles(GRADE_NS, CLK_NS, MARGIN);
  localparam int unsigned WP_CYC  = wp_cycles(GRADE_NS, CLK_NS, MARGIN);
  localparam int unsigned REC_CYC = rec_cycles(GRADE_NS, CLK_NS, MARGIN);
  localparam int unsigned MAX_CYC = max2(max2(RD_CYC, WP_CYC), REC_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic   accept;
  logic   rd_capture;
  phase_e phase;

  sram_strobe_seq #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .rd_capture(rd_capture),
    .rsp_pulse (rsp_valid),
    .ce_n      (ram_ce_n),
    .we_n      (ram_we_n),
    .oe_n      (ram_oe_n),
    .dq_oe     (ram_dq_oe),
    .phase     (phase)
  );

  sram_strobe_dp #(
    .AW(AW),
    .DW(DW)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .rd_capture(rd_capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ram_dq_i  (ram_dq_i),
    .ram_addr  (ram_addr),
    .ram_dq_o  (ram_dq_o),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/sram_strobe_chk.sv
module sram_strobe_chk
  import sram_strobe_pkg::*;
#(
  parameter int unsigned CLK_NS   = 5,
  parameter int unsigned GRADE_NS = 55,
  parameter int unsigned MARGIN   = 1,
  parameter int unsigned AW       = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic          rsp_valid,
  input logic [AW-1:0] ram_addr,
  input logic          ram_ce_n,
  input logic          ram_we_n,
  input logic          ram_oe_n,
  input logic          ram_dq_oe,
  input logic          accept,
  input logic          rd_capture
);

  localparam int unsigned WP_CYC = wp_cycles(GRADE_NS, CLK_NS, MARGIN);

  logic [7:0] low_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)         low_cnt <= '0;
    else if (!ram_we_n) low_cnt <= low_cnt + 1'b1;
    else                low_cnt <= '0;
  end

  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_after_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> rsp_valid);

  p_we_inside_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> !ram_ce_n);

  p_rec_keeps_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> !ram_ce_n);

  p_strobe_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (low_cnt == 8'(WP_CYC)));

  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> (ram_oe_n && !ram_we_n));

  p_oe_we_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_oe_n |-> ram_we_n);

  p_turn_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_oe_n) |-> (ram_ce_n && !req_ready));

  p_idle_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ram_ce_n);

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_ce_n && $past(!ram_ce_n)) |-> $stable(ram_addr));

  p_write_no_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> !rsp_valid);

endmodule

bind sram_strobe_ctl sram_strobe_chk #(
  .CLK_NS  (CLK_NS),
  .GRADE_NS(GRADE_NS),
  .MARGIN  (MARGIN),
  .AW      (AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .ram_addr  (ram_addr),
  .ram_ce_n  (ram_ce_n),
  .ram_we_n  (ram_we_n),
  .ram_oe_n  (ram_oe_n),
  .ram_dq_oe (ram_dq_oe),
  .accept    (accept),
  .rd_capture(rd_capture)
);

// File: tb/tb_sram_strobe_ctl.sv
module tb_sram_strobe_ctl;

  // expected phase lengths, 55 ns grade on a 5 ns clock, one margin cycle
  localparam int EXP_RD  = (55 + 4) / 5 + 1;                      // 12
  localparam int EXP_WP  = (45 + 4) / 5 + 1;                      // worst of 40/25/45 -> 10
  localparam int EXP_REC = ((55 + 4) / 5 + 1) - 1 - EXP_WP < 1 ? 1
                         : ((55 + 4) / 5 + 1) - 1 - EXP_WP;       // 1

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [18:0] ram_addr;
  logic        ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [7:0]  ram_dq_o;
  logic [7:0]  ram_dq_i;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  sram_strobe_ctl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
    .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i)
  );

  // behavioural RAM, low 8 address bits
  logic [7:0] mem [0:255];
  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  always @(posedge ram_we_n) if (!ram_ce_n) mem[ram_addr[7:0]] = ram_dq_o;
  assign ram_dq_i = (!ram_ce_n && !ram_oe_n && ram_we_n) ? mem[ram_addr[7:0]] : 8'h00;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wait_ready();
    int guard = 0;
    while (!req_ready && guard < 100) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // called at the negedge of the first cycle after a store was accepted
  task automatic measure_write(input logic [18:0] a, input logic [7:0] d);
    int setup = 0, pulse = 0, rec = 0, guard = 0;
    bit bad_oe = 0, bad_drv = 0, bad_addr = 0, bad_data = 0, bad_rdy = 0, bad_rsp = 0;
    while (!ram_ce_n && guard < 100) begin
      if (!ram_we_n) begin
        pulse++;
        if (!ram_dq_oe) bad_drv = 1;
        if (ram_dq_o != d) bad_data = 1;
      end else begin
        if (pulse == 0) setup++; else rec++;
        if (ram_dq_oe) bad_drv = 1;
      end
      if (!ram_oe_n) bad_oe = 1;
      if (ram_addr != a) bad_addr = 1;
      if (req_ready) bad_rdy = 1;
      if (rsp_valid) bad_rsp = 1;
      guard++;
      @(negedge clk);
    end
    check(setup == 1, "R5", "setup cycles", setup, 1);
    check(pulse == EXP_WP, "R5", "strobe-low cycles", pulse, EXP_WP);
    check(rec == EXP_REC, "R5", "recovery cycles", rec, EXP_REC);
    check(!bad_oe, "R6", "output enable low during store", bad_oe, 0);
    check(!bad_drv, "R6", "drive enable not matching strobe", bad_drv, 0);
    check(!bad_data, "R10", "store byte on pins", ram_dq_o, d);
    check(!bad_addr, "R9", "address held during store", ram_addr, a);
    check(!bad_rdy, "R2", "ready low while storing", bad_rdy, 0);
    check(!bad_rsp, "R11", "no response for a store", bad_rsp, 0);
    check(req_ready && ram_ce_n, "R8", "idle deselected after store", req_ready, 1);
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    wait_ready();
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    measure_write(a, d);
  endtask

  // poke: drive a stray store while busy; queue: present a store at the response cycle
  task automatic do_read(input logic [18:0] a, input logic [7:0] exp, input bit poke,
                         input bit queue, input logic [18:0] qa, input logic [7:0] qd);
    int n = 0, guard = 0;
    bit bad_strobe = 0, bad_addr = 0, bad_rdy = 0;
    wait_ready();
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid && guard < 100) begin
      if (ram_ce_n || ram_oe_n || !ram_we_n || ram_dq_oe) bad_strobe = 1;
      else n++;
      if (ram_addr != a) bad_addr = 1;
      if (req_ready) bad_rdy = 1;
      if (poke && n == 3) begin
        req_valid = 1; req_write = 1; req_addr = a ^ 19'h5; req_wdata = 8'hEE;
      end
      if (poke && n == 7) req_valid = 0;
      guard++;
      @(negedge clk);
    end
    check(n == EXP_RD, "R3", "load strobe cycles", n, EXP_RD);
    check(!bad_strobe, "R3", "strobe pattern in load", bad_strobe, 0);
    check(!bad_addr, "R9", "address held during load", ram_addr, a);
    check(!bad_rdy, "R2", "ready low while loading", bad_rdy, 0);
    if (poke) check(!bad_strobe && !bad_addr, "R11", "busy request ignored", bad_addr, 0);
    check(rsp_valid && rsp_rdata == exp, "R4", "load data", rsp_rdata, exp);
    check(ram_ce_n && !req_ready && !ram_dq_oe, "R7", "turnaround cycle", ram_ce_n, 1);
    if (queue) begin
      int gap = 0;
      req_valid = 1; req_write = 1; req_addr = qa; req_wdata = qd;
      @(negedge clk);
      check(!rsp_valid, "R4", "response pulse one cycle", rsp_valid, 0);
      gap = 1;
      while (ram_ce_n && gap < 20) begin
        if (ram_dq_oe) gap = 99;
        gap++;
        @(negedge clk);
      end
      req_valid = 0;
      check(gap == 2, "R7", "deselected cycles before queued store", gap, 2);
      measure_write(qa, qd);
    end else begin
      @(negedge clk);
      check(!rsp_valid, "R4", "response pulse one cycle", rsp_valid, 0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(ram_ce_n && ram_we_n && ram_oe_n, "R1", "strobes high in reset",
          {ram_ce_n, ram_we_n, ram_oe_n}, 7);
    check(!ram_dq_oe && !rsp_valid, "R1", "no drive, no response in reset", ram_dq_oe, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && ram_ce_n, "R1", "ready after reset", req_ready, 1);
  endtask

  task automatic t_store_patterns();
    do_write(19'h00010, 8'hA5);
    do_write(19'h7FF22, 8'h5A);
    do_write(19'h00033, 8'hFF);
    do_write(19'h00044, 8'h00);
  endtask

  task automatic t_load_back();
    do_read(19'h00010, 8'hA5, 0, 0, '0, '0);
    do_read(19'h7FF22, 8'h5A, 0, 0, '0, '0);
    do_read(19'h00033, 8'hFF, 0, 0, '0, '0);
  endtask

  task automatic t_busy_ignored();
    do_write(19'h00015, 8'h3C);             // 0x10 ^ 0x5 holds a known byte
    do_read(19'h00010, 8'hA5, 1, 0, '0, '0);
    check(mem[8'h15] == 8'h3C, "R11", "stray store not performed", mem[8'h15], 8'h3C);
    do_read(19'h00015, 8'h3C, 0, 0, '0, '0);
  endtask

  task automatic t_load_then_store();
    do_read(19'h00044, 8'h00, 0, 1, 19'h00055, 8'hC3);
    do_read(19'h00055, 8'hC3, 0, 0, '0, '0);
  endtask

  task automatic t_store_then_load();
    do_write(19'h00066, 8'h81);
    check(req_ready && ram_ce_n, "R8", "one deselected cycle after store", ram_ce_n, 1);
    do_read(19'h00066, 8'h81, 0, 0, '0, '0);
  endtask

  initial begin
    t_reset();
    t_store_patterns();
    t_load_back();
    t_busy_ignored();
    t_load_then_store();
    t_store_then_load();
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule